// File: doc/BRIEF.md
# Shadow Memory Store/Recall Controller

This block is a byte-wide working memory that keeps a nonvolatile shadow copy of itself. The four active-low control pins are chip enable (`ce_n`), output enable (`oe_n`), write enable (`we_n`) and nonvolatile enable (`nve_n`). The block decodes them into standby, read, write, store and recall. Read and write act on the working array. A store copies the whole working array into the shadow array. A recall replaces the working array with the shadow contents. Both arrays are register models inside the block.

All pins, the address, the write data and the supply-low flag pass through a synchroniser first. A store or recall starts only when the synchronised pins enter the transfer state. The state must then stay unchanged for `QUAL_CYC` cycles. Once a transfer starts it runs for a fixed number of clock cycles (`STORE_CYC` or `RECALL_CYC`) and `busy` stays high the whole time. During that window the copy moves one word per clock, the bus is not driven and pin activity is ignored. A pin state that started a transfer must be left and entered again before another transfer can begin. A store is refused while the supply-low flag is high.

The address width is a parameter. The full part needs a 13-bit address (8192 bytes), while the default build uses 8 bits to keep the two register arrays small. The transfer windows must be at least one word per address: `STORE_CYC >= 2**ADDR_W` and `RECALL_CYC >= 2**ADDR_W`.

Top module: `nvs_shadow_mem`

## Requirements
- R1: After reset `busy` and `dq_oe` are low.
- R2: With `ce_n`=0, `oe_n`=0, `we_n`=1 and `nve_n`=1, the block drives `dq_oe`=1 and `dq_out` = the working word at `addr`. The output is valid `SYNC_STAGES` clocks after the pins change.
- R3: With `ce_n`=0, `we_n`=0 and `nve_n`=1, `dq_in` is written to the working word at `addr`. `dq_oe` stays 0 even when `oe_n`=0.
- R4: With `ce_n`=1, or with all four pins low, the block writes nothing, starts no transfer and keeps `dq_oe`=0.
- R5: A store (`ce_n`=0, `we_n`=0, `nve_n`=0, `oe_n`=1) sets `busy` for exactly `STORE_CYC` cycles. The shadow array then equals the working array as it was at the start.
- R6: A recall (`ce_n`=0, `oe_n`=0, `nve_n`=0, `we_n`=1) sets `busy` for exactly `RECALL_CYC` cycles. The working array then equals the shadow array, and the shadow array is unchanged.
- R7: While `busy` is high, `dq_oe`=0 and read or write pin states change no memory word.
- R8: Once a transfer has started, it completes its full duration even if the pins leave the transfer state.
- R9: Holding the pins in a transfer state after the transfer ends starts no new transfer. The pins must first leave that state and then enter it again.
- R10: No store starts while `vlow`=1. A store state that qualified while `vlow`=1 is used up: it does not start a store when `vlow` later falls while the pins are still held.
- R11: A transfer pin state held for fewer than `QUAL_CYC` synchronised cycles starts nothing.
- R12: When a transfer ends, a read state already on the pins drives the bus in the first cycle that `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| nve_n | input | 1 | Nonvolatile enable, active low |
| vlow | input | 1 | Supply below the store threshold |
| addr | input | ADDR_W | Word address |
| dq_in | input | 8 | Write data from the pad |
| dq_out | output | 8 | Read data to the pad |
| dq_oe | output | 1 | Pad output enable (1 = drive) |
| busy | output | 1 | Store or recall in progress |

## Verification
The bench goes after retriggering:
- A block that acts on the pin level instead of on an entry into the state would start a second store right after the first one while the pins are still held (R9).
- A block that never re-arms would not start one after the pins leave and come back.

It measures the `busy` window exactly:
- Releasing the pins early must not shorten it (R8).
- A one-cycle glitch into the store state must not start it (R11).

It checks that a store refused for low supply does not fire later when the flag drops (R10).

It drives a write state during a recall, which must be lost. It leaves a read state waiting at the end, which must appear in the first idle cycle (R7, R12). A recall run twice over a modified working array shows whether the recall corrupts the shadow copy (R6).

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [2:0] {
    MD_STBY,
    MD_READ,
    MD_WRITE,
    MD_STORE,
    MD_RECALL,
    MD_NOP
  } nvs_mode_e;

  typedef enum logic [1:0] {
    XF_IDLE,
    XF_STORE,
    XF_RECALL
  } nvs_xfer_e;

  // Pin decode, all inputs active low.
  function automatic nvs_mode_e nvs_decode(input logic ce_n, input logic oe_n,
                                           input logic we_n, input logic nve_n);
    nvs_mode_e m;
    if (ce_n)                 m = MD_STBY;
    else if (nve_n && !we_n)  m = MD_WRITE;
    else if (nve_n && !oe_n)  m = MD_READ;
    else if (nve_n)           m = MD_NOP;
    else if (!oe_n && we_n)   m = MD_RECALL;
    else if (oe_n && !we_n)   m = MD_STORE;
    else                      m = MD_NOP;
    return m;
  endfunction

endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '1;
      else        stg <= d;
    end
  end else begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '1;
      else        stg <= {stg[STAGES-2:0], d};
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/nvs_qual.sv
module nvs_qual
  import nvs_pkg::*;
#(
  parameter int QUAL_CYC = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  nvs_mode_e mode,
  input  logic      vlow,
  input  logic      busy,
  output logic      start_store,
  output logic      start_recall
);

  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUAL_CYC - 1);

  nvs_mode_e     mode_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          arm_q, arm_d;
  logic          is_nv, qual;

  assign is_nv = (mode == MD_STORE) || (mode == MD_RECALL);
  assign qual  = (mode == mode_q) && (cnt_q == QMAX);

  always_comb begin
    if (mode != mode_q)    cnt_d = '0;
    else if (cnt_q == QMAX) cnt_d = cnt_q;
    else                   cnt_d = cnt_q + CW'(1);

    arm_d = arm_q;
    if (!busy) begin
      if (!is_nv)              arm_d = 1'b1;
      else if (qual && arm_q)  arm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_STBY;
      cnt_q  <= '0;
      arm_q  <= 1'b0;
    end else begin
      mode_q <= mode;
      cnt_q  <= cnt_d;
      arm_q  <= arm_d;
    end
  end

  assign start_store  = !busy && arm_q && qual && (mode == MD_STORE) && !vlow;
  assign start_recall = !busy && arm_q && qual && (mode == MD_RECALL);

  // R9: a start is a single pulse, never two in a row
  a_r9_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_store || start_recall) |=> !(start_store || start_recall));

endmodule

// File: rtl/nvs_xfer.sv
module nvs_xfer
  import nvs_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int STORE_CYC  = 600,
  parameter int RECALL_CYC = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_store,
  input  logic              start_recall,
  output nvs_xfer_e         xf_state,
  output logic              busy,
  output logic              cp_en,
  output logic              cp_to_work,
  output logic [ADDR_W-1:0] cp_idx
);

  localparam int MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam int IW   = ADDR_W + 1;

  nvs_xfer_e     st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    idx_d = idx_q;
    case (st_q)
      XF_IDLE: begin
        if (start_store) begin
          st_d  = XF_STORE;
          tmr_d = TW'(STORE_CYC - 1);
          idx_d = '0;
        end else if (start_recall) begin
          st_d  = XF_RECALL;
          tmr_d = TW'(RECALL_CYC - 1);
          idx_d = '0;
        end
      end
      default: begin
        if (tmr_q == '0) st_d  = XF_IDLE;
        else             tmr_d = tmr_q - TW'(1);
        if (!idx_q[ADDR_W]) idx_d = idx_q + IW'(1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= XF_IDLE;
      tmr_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      idx_q <= idx_d;
    end
  end

  assign xf_state   = st_q;
  assign busy       = (st_q != XF_IDLE);
  assign cp_en      = busy && !idx_q[ADDR_W];
  assign cp_to_work = (st_q == XF_RECALL);
  assign cp_idx     = idx_q[ADDR_W-1:0];

  // R7: the qualifier never requests a transfer while one is running
  a_r7_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(start_store || start_recall));

  // R5: an accepted request makes the block busy on the next cycle
  a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_store || start_recall) |=> busy);

endmodule

// File: rtl/nvs_shadow_mem.sv
module nvs_shadow_mem
  import nvs_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int STORE_CYC   = 600,
  parameter int RECALL_CYC  = 300,
  parameter int QUAL_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              nve_n,
  input  logic              vlow,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic              busy
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SW    = 5 + ADDR_W + 8;

  logic [SW-1:0]     raw, syn;
  logic              s_ce_n, s_oe_n, s_we_n, s_nve_n, s_vlow;
  logic [ADDR_W-1:0] s_addr;
  logic [7:0]        s_din;
  nvs_mode_e         mode;
  nvs_xfer_e         xf;
  logic              st_store, st_recall;
  logic              cp_en, cp_to_work;
  logic [ADDR_W-1:0] cp_idx;
  logic              wr_en, sh_we, wk_cp;

  assign raw = {ce_n, oe_n, we_n, nve_n, vlow, addr, dq_in};

  nvs_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  assign s_ce_n  = syn[12+ADDR_W];
  assign s_oe_n  = syn[11+ADDR_W];
  assign s_we_n  = syn[10+ADDR_W];
  assign s_nve_n = syn[9+ADDR_W];
  assign s_vlow  = syn[8+ADDR_W];
  assign s_addr  = syn[8 +: ADDR_W];
  assign s_din   = syn[7:0];

  assign mode = nvs_decode(s_ce_n, s_oe_n, s_we_n, s_nve_n);

  nvs_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .mode(mode), .vlow(s_vlow), .busy(busy),
    .start_store(st_store), .start_recall(st_recall)
  );

  nvs_xfer #(.ADDR_W(ADDR_W), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start_store(st_store), .start_recall(st_recall),
    .xf_state(xf), .busy(busy), .cp_en(cp_en), .cp_to_work(cp_to_work),
    .cp_idx(cp_idx)
  );

  // Working and shadow arrays: storage cells, no reset.
  logic [7:0] wk [DEPTH];
  logic [7:0] sh [DEPTH];

  assign wr_en = (mode == MD_WRITE) && !busy;
  assign sh_we = cp_en && !cp_to_work;
  assign wk_cp = cp_en && cp_to_work;

  always_ff @(posedge clk) begin
    if (wk_cp)      wk[cp_idx] <= sh[cp_idx];
    else if (wr_en) wk[s_addr] <= s_din;
    if (sh_we)      sh[cp_idx] <= wk[cp_idx];
  end

  assign dq_out = wk[s_addr];
  assign dq_oe  = (mode == MD_READ) && !busy;

  // R10: a store never begins from a cycle with the supply flag raised
  a_r10_store_supply: assert property (@(posedge clk) disable iff (!rst_n)
    (xf == XF_STORE && $past(xf) == XF_IDLE) |-> !$past(s_vlow));

  // R4: deselected chip never drives the bus
  a_r4_standby_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    s_ce_n |-> !dq_oe);

  // R6: the shadow array is written only inside a store window
  a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sh_we |-> (xf == XF_STORE));

endmodule

// File: tb/sim_nvs_shadow_mem.sv
module sim_nvs_shadow_mem;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 4;
  localparam int N    = 1 << AW;
  localparam int SCYC = 40;
  localparam int RCYC = 30;
  localparam int QCYC = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, we_n, nve_n, vlow;
  logic [AW-1:0] addr;
  logic [7:0]    dq_in, dq_out;
  logic          dq_oe, busy;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] exp_wk [N];
  logic [7:0] exp_sh [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvs_shadow_mem #(.ADDR_W(AW), .STORE_CYC(SCYC), .RECALL_CYC(RCYC),
                   .QUAL_CYC(QCYC), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .nve_n(nve_n), .vlow(vlow), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input logic e, input logic g, input logic w, input logic ne);
    ce_n = e; oe_n = g; we_n = w; nve_n = ne;
  endtask

  task automatic do_write(input int a, input logic [7:0] d);
    addr = AW'(a); dq_in = d; pins(0, 1, 0, 1); tick(3);
    pins(1, 1, 1, 1); tick(3);
    exp_wk[a] = d;
  endtask

  task automatic do_read(input int a, input string req);
    addr = AW'(a); pins(0, 0, 1, 1); tick(3);
    chk(dq_oe === 1'b1, req, int'(dq_oe), 1);
    chk(dq_out === exp_wk[a], req, int'(dq_out), int'(exp_wk[a]));
    pins(1, 1, 1, 1); tick(2);
  endtask

  // waits up to lim cycles for busy; returns the measured high length or -1
  task automatic busy_len(input int lim, input bit release_pins, output int len);
    int w = 0;
    while (busy !== 1'b1 && w < lim) begin tick(1); w++; end
    if (busy !== 1'b1) begin len = -1; return; end
    if (release_pins) pins(1, 1, 1, 1);
    len = 0;
    while (busy === 1'b1 && len < 5000) begin len++; tick(1); end
  endtask

  task automatic t_reset();
    chk(busy === 1'b0, "R1", int'(busy), 0);
    chk(dq_oe === 1'b0, "R1", int'(dq_oe), 0);
  endtask

  task automatic t_fill_read();
    for (int i = 0; i < N; i++) do_write(i, 8'((i * 37 + 5) & 255));
    for (int i = 0; i < N; i += 5) do_read(i, "R2");
  endtask

  task automatic t_write_g_low();
    addr = 7; dq_in = 8'h5A; pins(0, 0, 0, 1); tick(3);
    chk(dq_oe === 1'b0, "R3", int'(dq_oe), 0);
    pins(1, 1, 1, 1); tick(3);
    exp_wk[7] = 8'h5A;
    do_read(7, "R3");
  endtask

  task automatic t_deselect();
    int len;
    addr = 2; dq_in = 8'h11; pins(1, 1, 0, 1); tick(4);
    chk(dq_oe === 1'b0, "R4", int'(dq_oe), 0);
    pins(0, 0, 0, 0); tick(4);
    chk(dq_oe === 1'b0, "R4", int'(dq_oe), 0);
    busy_len(15, 0, len);
    chk(len == -1, "R4", len, -1);
    pins(1, 1, 1, 1); tick(3);
    do_read(2, "R4");
  endtask

  task automatic t_short();
    int len;
    pins(0, 1, 0, 0); tick(1);
    pins(1, 1, 1, 1);
    busy_len(25, 0, len);
    chk(len == -1, "R11", len, -1);
  endtask

  task automatic t_store();
    int len;
    pins(0, 1, 0, 0);
    busy_len(30, 1, len);
    chk(len == SCYC, "R5 R8", len, SCYC);
    for (int i = 0; i < N; i++) exp_sh[i] = exp_wk[i];
    tick(3);
  endtask

  task automatic t_retrigger();
    int len;
    pins(0, 1, 0, 0);
    busy_len(30, 0, len);
    chk(len == SCYC, "R9", len, SCYC);
    busy_len(30, 0, len);
    chk(len == -1, "R9", len, -1);
    pins(1, 1, 1, 1); tick(5);
    pins(0, 1, 0, 0);
    busy_len(30, 1, len);
    chk(len == SCYC, "R9", len, SCYC);
    tick(3);
  endtask

  task automatic t_vlow();
    int len;
    vlow = 1'b1; tick(3);
    pins(0, 1, 0, 0);
    busy_len(30, 0, len);
    chk(len == -1, "R10", len, -1);
    vlow = 1'b0;
    busy_len(30, 0, len);
    chk(len == -1, "R10", len, -1);
    pins(1, 1, 1, 1); tick(5);
    pins(0, 1, 0, 0);
    busy_len(30, 1, len);
    chk(len == SCYC, "R10", len, SCYC);
    tick(3);
  endtask

  task automatic t_recall();
    int len;
    for (int i = 0; i < N; i++) do_write(i, ~exp_sh[i]);
    pins(0, 0, 1, 0);
    busy_len(30, 1, len);
    chk(len == RCYC, "R6", len, RCYC);
    for (int i = 0; i < N; i++) exp_wk[i] = exp_sh[i];
    tick(3);
    for (int i = 0; i < N; i += 3) do_read(i, "R6");
    do_write(0, 8'hC3);
    pins(0, 0, 1, 0);
    busy_len(30, 1, len);
    chk(len == RCYC, "R6", len, RCYC);
    exp_wk[0] = exp_sh[0];
    tick(3);
    do_read(0, "R6");
  endtask

  task automatic t_busy_resume();
    int w = 0;
    pins(0, 0, 1, 0);
    while (busy !== 1'b1 && w < 30) begin tick(1); w++; end
    chk(busy === 1'b1, "R7", int'(busy), 1);
    tick(6);
    addr = 3; dq_in = 8'hEE; pins(0, 0, 0, 1); tick(5);
    chk(dq_oe === 1'b0, "R7", int'(dq_oe), 0);
    addr = 5; pins(0, 0, 1, 1); tick(4);
    chk(dq_oe === 1'b0, "R7", int'(dq_oe), 0);
    w = 0;
    while (busy === 1'b1 && w < 100) begin tick(1); w++; end
    chk(dq_oe === 1'b1, "R12", int'(dq_oe), 1);
    chk(dq_out === exp_wk[5], "R12", int'(dq_out), int'(exp_wk[5]));
    pins(1, 1, 1, 1); tick(3);
    do_read(3, "R7");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pins(1, 1, 1, 1); vlow = 1'b0; addr = '0; dq_in = '0;
    tick(3);
    t_reset();
    rst_n = 1'b1; tick(3);
    t_reset();
    t_fill_read();
    t_write_g_low();
    t_deselect();
    t_short();
    t_store();
    t_retrigger();
    t_vlow();
    t_recall();
    t_busy_resume();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule